// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the control word and the event/status word for one hot-pluggable slot on a downstream port. Software reaches both words through a simple single-cycle register bus: a write is taken on the clock edge where request and write-enable are high, and read data is returned combinationally while request is high and write-enable is low. The control word at byte address B8h sets the power and attention indicators, the slot power switch, an electromechanical interlock and the per-event notification enables. The status word at byte address BAh reports whether a card is present and holds sticky event flags.

The raw slot signals (in-band presence, out-of-band presence, attention button, power fault and retention-latch sensor) are synchronised and debounced inside the block. Edges of the filtered signals set the sticky flags, and software clears a flag by writing 1 to it. A level notification output stays high while any flag is set together with its enable. Indicator codes become steady or blinking drive levels, and the blink rate comes from a free-running prescaler. Capability parameters remove the button, fault, latch-sensor or slot features. A port built without a slot always reports a card as present.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset, with all slot inputs low, the control word (address B8h) and the status word (address BAh) both read 0000h, the power enable output is 1 and the interlock and notification outputs are 0.
- R2: Control bits [3:0], [9:6], [10] and [12] read back exactly as last written.
- R3: Writing 1 to control bit 11 inverts the interlock output. Writing 0 there leaves it unchanged. Bit 11 always reads 0.
- R4: Each indicator field (power at [9:8], attention at [7:6]) drives its output as follows: code 01 gives steady 1, codes 11 and 00 give 0, and code 10 gives a square wave of period 2^BLINK_LOG2 cycles that is high for half of each period.
- R5: The power enable output equals the inverse of control bit 10 (0 = power on).
- R6: Status bit 6 is the OR of the debounced in-band and out-of-band presence inputs. Any change of that OR sets status bit 3.
- R7: A rising edge of the filtered button sets status bit 0, and a rising edge of the filtered power fault sets bit 1. Either edge of the filtered latch sensor sets bit 2. Falling edges of the button and of the power fault set nothing.
- R8: Writing 1 to any of status bits [3:0] clears that bit. Writing 0 leaves it unchanged, and a flag is never cleared without such a write.
- R9: The notification output is high exactly when some status bit n in [3:0] and control bit n are both 1.
- R10: A slot input pulse lasting fewer than DEB_CYCLES cycles at the synchroniser output changes no status bit.
- R11: Reserved bits read 0: control [15:13] and [5:4], status [15:7] and [5:4]. A write to any address other than B8h or BAh changes nothing.
- R12: With HAS_SLOT=0, status bit 6 always reads 1 and bit 3 never sets. With a capability parameter at 0, its flag (button bit 0, fault bit 1, latch bit 2) never sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while a read is requested |
| prsnt_inband | input | 1 | Raw in-band presence |
| prsnt_oob | input | 1 | Raw out-of-band presence |
| attn_btn | input | 1 | Raw attention button, 1 = pressed |
| pwr_fault | input | 1 | Raw power fault, 1 = fault |
| mrl_open | input | 1 | Raw retention-latch sensor |
| pwr_ind | output | 1 | Power indicator drive |
| attn_ind | output | 1 | Attention indicator drive |
| pwr_en | output | 1 | Slot power switch, 1 = on |
| interlock | output | 1 | Electromechanical interlock drive |
| irq | output | 1 | Level notification |

## Verification
A wrongly held control bit shows up on the next read and, for bits 10 and 11, on the power enable or interlock pin in the cycle after the write. A lost or spurious event flag changes the status read and the notification pin once the synchroniser and debounce delay have passed, about DEB_CYCLES+3 cycles after the raw input moves. A wrong blink prescaler shows only when the high cycles of an indicator are counted over whole periods. The bench therefore counts them over two full periods.

// File: rtl/hp_pkg.sv
package hp_pkg;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_code_e;

    typedef struct packed {
        logic [2:0] rsv_hi;
        logic       dll_en;
        logic       ilock;
        logic       pwr_off;
        ind_code_e  pwr_code;
        ind_code_e  attn_code;
        logic [1:0] rsv_lo;
        logic [3:0] ev_en;
    } slot_ctl_t;

    typedef struct packed {
        logic [8:0] rsv_hi;
        logic       pres_state;
        logic [1:0] rsv_mid;
        logic [3:0] ev_flag;
    } slot_sts_t;

    localparam logic [15:0] CTL_WMASK = 16'h17CF;

    localparam int IN_INB  = 0;
    localparam int IN_OOB  = 1;
    localparam int IN_BTN  = 2;
    localparam int IN_PF   = 3;
    localparam int IN_MRL  = 4;
    localparam int NUM_IN  = 5;

    function automatic logic ind_drive(input ind_code_e code, input logic phase);
        case (code)
            IND_ON:    return 1'b1;
            IND_BLINK: return phase;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hp_debounce.sv
module hp_debounce #(
    parameter int W          = 5,
    parameter int DEB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic          s1, s2, q;
        logic [CW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1  <= 1'b0;
                s2  <= 1'b0;
                q   <= 1'b0;
                cnt <= '0;
            end else begin
                s1 <= raw[i];
                s2 <= s1;
                if (s2 == q) begin
                    cnt <= '0;
                end else if (cnt == CW'(DEB_CYCLES - 1)) begin
                    q   <= s2;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
        assign clean[i] = q;
    end
endmodule

// File: rtl/hp_blink.sv
module hp_blink #(
    parameter int BLINK_LOG2 = 4
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    logic [BLINK_LOG2-1:0] cnt;
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end
    assign phase = cnt[BLINK_LOG2-1];
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
#(
    parameter logic [7:0] CTL_ADDR   = 8'hB8,
    parameter logic [7:0] STS_ADDR   = 8'hBA,
    parameter int         DEB_CYCLES = 4,
    parameter int         BLINK_LOG2 = 4,
    parameter bit         HAS_SLOT   = 1'b1,
    parameter bit         HAS_BUTTON = 1'b1,
    parameter bit         HAS_PFAULT = 1'b1,
    parameter bit         HAS_MRL    = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        prsnt_inband,
    input  logic        prsnt_oob,
    input  logic        attn_btn,
    input  logic        pwr_fault,
    input  logic        mrl_open,
    output logic        pwr_ind,
    output logic        attn_ind,
    output logic        pwr_en,
    output logic        interlock,
    output logic        irq
);
    localparam logic [3:0] CAP = {HAS_SLOT, HAS_MRL, HAS_PFAULT, HAS_BUTTON};

    logic [NUM_IN-1:0] raw, cln, cln_q;
    logic              phase, pres, pres_q;
    logic [3:0]        ev, sts_ev_q;
    slot_ctl_t         ctl_q;
    slot_sts_t         sts_view;
    logic              ilock_q, wr_ctl, wr_sts;

    assign raw[IN_INB] = prsnt_inband;
    assign raw[IN_OOB] = prsnt_oob;
    assign raw[IN_BTN] = attn_btn;
    assign raw[IN_PF]  = pwr_fault;
    assign raw[IN_MRL] = mrl_open;

    hp_debounce #(.W(NUM_IN), .DEB_CYCLES(DEB_CYCLES)) u_deb (
        .clk(clk), .rst(rst), .raw(raw), .clean(cln)
    );

    hp_blink #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
        .clk(clk), .rst(rst), .phase(phase)
    );

    if (HAS_SLOT) begin : g_slot
        assign pres = cln[IN_INB] | cln[IN_OOB];
    end else begin : g_noslot
        assign pres = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cln_q  <= '0;
            pres_q <= 1'b0;
        end else begin
            cln_q  <= cln;
            pres_q <= pres;
        end
    end

    // edge detection per event source, then capability gating
    assign ev = CAP & {pres ^ pres_q,
                       cln[IN_MRL] ^ cln_q[IN_MRL],
                       cln[IN_PF]  & ~cln_q[IN_PF],
                       cln[IN_BTN] & ~cln_q[IN_BTN]};

    assign wr_ctl = bus_req & bus_we & (bus_addr == CTL_ADDR);
    assign wr_sts = bus_req & bus_we & (bus_addr == STS_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            ilock_q  <= 1'b0;
            sts_ev_q <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_q   <= slot_ctl_t'(bus_wdata & CTL_WMASK);
                ilock_q <= ilock_q ^ bus_wdata[11];
            end
            sts_ev_q <= (sts_ev_q & ~(wr_sts ? bus_wdata[3:0] : 4'h0)) | ev;
        end
    end

    always_comb begin
        sts_view            = '0;
        sts_view.pres_state = pres;
        sts_view.ev_flag    = sts_ev_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            if (bus_addr == CTL_ADDR)      bus_rdata = ctl_q;
            else if (bus_addr == STS_ADDR) bus_rdata = sts_view;
        end
    end

    assign pwr_ind   = ind_drive(ctl_q.pwr_code, phase);
    assign attn_ind  = ind_drive(ctl_q.attn_code, phase);
    assign pwr_en    = ~ctl_q.pwr_off;
    assign interlock = ilock_q;
    assign irq       = |(sts_ev_q & ctl_q.ev_en);

endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk #(
    parameter logic [7:0] CTL_ADDR = 8'hB8,
    parameter logic [7:0] STS_ADDR = 8'hBA
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic [15:0] bus_rdata,
    input logic        pwr_en,
    input logic        interlock,
    input logic        pwr_ind,
    input logic        irq,
    input logic [1:0]  pwr_code,
    input logic [3:0]  ev_en,
    input logic [3:0]  sts_ev
);
    logic wr_c, wr_s;
    assign wr_c = bus_req && bus_we && bus_addr == CTL_ADDR;
    assign wr_s = bus_req && bus_we && bus_addr == STS_ADDR;

    assert_ilock_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_c && bus_wdata[11]) |=> (interlock != $past(interlock)));
    assert_ilock_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_c && bus_wdata[11]) |=> $stable(interlock));
    assert_pwr_en_R5: assert property (@(posedge clk) disable iff (rst)
        wr_c |=> (pwr_en == !$past(bus_wdata[10])));
    assert_ind_off_R4: assert property (@(posedge clk) disable iff (rst)
        (pwr_code == 2'b11 || pwr_code == 2'b00) |-> !pwr_ind);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (sts_ev[0] && !(wr_s && bus_wdata[0])) |=> sts_ev[0]);
    assert_irq_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|ev_en) && (|sts_ev));
    assert_rsvd_ctl_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == CTL_ADDR) |->
            (bus_rdata[15:13] == 3'b0 && !bus_rdata[11] && bus_rdata[5:4] == 2'b0));
    assert_rsvd_sts_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == STS_ADDR) |->
            (bus_rdata[15:7] == 9'b0 && bus_rdata[5:4] == 2'b0));
endmodule

bind hp_slot_regs hp_slot_regs_chk #(.CTL_ADDR(CTL_ADDR), .STS_ADDR(STS_ADDR)) u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
    .interlock(interlock), .pwr_ind(pwr_ind), .irq(irq),
    .pwr_code(ctl_q.pwr_code), .ev_en(ctl_q.ev_en), .sts_ev(sts_ev_q)
);

// File: tb/sim_hp_slot_regs.sv
module sim_hp_slot_regs;
    localparam logic [7:0] CTL = 8'hB8;
    localparam logic [7:0] STS = 8'hBA;
    localparam int SETTLE = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 0, bus_we = 0;
    logic [7:0] bus_addr = 0;
    logic [15:0] bus_wdata = 0, rdata0, rdata1;
    logic inb = 0, oob = 0, btn = 0, pf = 0, mrl = 0;
    logic pwr_ind, attn_ind, pwr_en, interlock, irq;
    logic pwr_ind1, attn_ind1, pwr_en1, interlock1, irq1;

    int total = 0, bad = 0;
    logic ilock_m = 1'b0;

    always #2.5 clk = ~clk;

    hp_slot_regs u0 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .prsnt_inband(inb), .prsnt_oob(oob),
        .attn_btn(btn), .pwr_fault(pf), .mrl_open(mrl), .pwr_ind(pwr_ind),
        .attn_ind(attn_ind), .pwr_en(pwr_en), .interlock(interlock), .irq(irq)
    );

    hp_slot_regs #(.HAS_SLOT(1'b0), .HAS_BUTTON(1'b0), .HAS_PFAULT(1'b0), .HAS_MRL(1'b0)) u1 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .prsnt_inband(inb), .prsnt_oob(oob),
        .attn_btn(btn), .pwr_fault(pf), .mrl_open(mrl), .pwr_ind(pwr_ind1),
        .attn_ind(attn_ind1), .pwr_en(pwr_en1), .interlock(interlock1), .irq(irq1)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
        if (a == CTL && d[11]) ilock_m = ~ilock_m;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d0, output logic [15:0] d1);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a;
        #1;
        d0 = rdata0; d1 = rdata1;
        bus_req = 0;
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    function automatic logic ind_exp(input logic [1:0] c);
        return c == 2'b01;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r0, r1;
        logic [31:0] rv;
        int hi;
        rv = $urandom(32'h5EED);
        repeat (4) @(negedge clk);
        rst = 0;

        // R1 reset state, R12 no-slot presence
        rd(CTL, r0, r1); chk("R1 ctl reset", r0, 16'h0000);
        rd(STS, r0, r1); chk("R1 sts reset", r0, 16'h0000);
        chk("R12 noslot presence", r1, 16'h0040);
        chk("R1 outputs", {12'b0, pwr_en, interlock, irq, pwr_ind}, 16'h0008);

        // R2 R11 R3 R5 R4
        wr(CTL, 16'hFFFF);
        rd(CTL, r0, r1); chk("R2 R11 ctl readback", r0, 16'h17CF);
        chk("R3 interlock toggled", {15'b0, interlock}, 16'h1);
        chk("R5 pwr_en off", {15'b0, pwr_en}, 16'h0);
        chk("R4 code 11 off", {14'b0, pwr_ind, attn_ind}, 16'h0);
        wr(CTL, 16'h0000);
        chk("R3 write 0 holds", {15'b0, interlock}, 16'h1);
        chk("R5 pwr_en on", {15'b0, pwr_en}, 16'h1);
        wr(CTL, 16'h0800);
        chk("R3 toggle back", {15'b0, interlock}, 16'h0);
        rd(CTL, r0, r1); chk("R3 bit11 reads 0", r0, 16'h0000);
        wr(CTL, 16'h0140);
        chk("R4 code 01 on", {14'b0, pwr_ind, attn_ind}, 16'h3);
        wr(CTL, 16'h0000);
        chk("R4 code 00 off", {14'b0, pwr_ind, attn_ind}, 16'h0);

        wr(CTL, 16'h0280);
        hi = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            hi += int'(pwr_ind) + int'(attn_ind);
        end
        chk("R4 blink duty", 16'(hi), 16'd32);

        wr(8'hBC, 16'hFFFF);
        rd(CTL, r0, r1); chk("R11 other address ignored", r0, 16'h0280);
        wr(CTL, 16'h0000);

        // R7 R9 R8
        btn = 1; settle();
        rd(STS, r0, r1); chk("R7 button press", r0, 16'h0001);
        chk("R9 irq masked", {15'b0, irq}, 16'h0);
        wr(CTL, 16'h0001);
        chk("R9 irq enabled", {15'b0, irq}, 16'h1);
        btn = 0; settle();
        rd(STS, r0, r1); chk("R7 release no event", r0, 16'h0001);
        wr(STS, 16'h0000);
        rd(STS, r0, r1); chk("R8 write 0 keeps", r0, 16'h0001);
        wr(STS, 16'h0001);
        rd(STS, r0, r1); chk("R8 write 1 clears", r0, 16'h0000);
        chk("R9 irq drops", {15'b0, irq}, 16'h0);

        pf = 1; settle();
        rd(STS, r0, r1); chk("R7 power fault", r0, 16'h0002);
        mrl = 1; settle();
        rd(STS, r0, r1); chk("R7 mrl rise", r0, 16'h0006);
        wr(STS, 16'h000F);
        pf = 0; mrl = 0; settle();
        rd(STS, r0, r1); chk("R7 mrl fall only", r0, 16'h0004);
        wr(CTL, 16'h0004);
        chk("R9 mrl enable", {15'b0, irq}, 16'h1);
        wr(STS, 16'h000F);

        // R6 presence
        inb = 1; settle();
        rd(STS, r0, r1); chk("R6 inband present", r0, 16'h0048);
        wr(STS, 16'h000F);
        oob = 1; settle();
        rd(STS, r0, r1); chk("R6 OR holds", r0, 16'h0040);
        inb = 0; settle();
        rd(STS, r0, r1); chk("R6 still present", r0, 16'h0040);
        oob = 0; settle();
        rd(STS, r0, r1); chk("R6 empty", r0, 16'h0008);
        chk("R12 noslot after events", r1, 16'h0040);
        wr(STS, 16'h000F);

        // R10 short glitch
        @(negedge clk); btn = 1;
        repeat (2) @(negedge clk); btn = 0;
        settle();
        rd(STS, r0, r1); chk("R10 glitch filtered", r0, 16'h0000);

        // random control writes with button flag set
        btn = 1; settle(); btn = 0; settle();
        for (int i = 0; i < 40; i++) begin
            logic [15:0] d;
            d = 16'($urandom());
            wr(CTL, d);
            rd(CTL, r0, r1); chk("R2 random readback", r0, d & 16'h17CF);
            chk("R3 random interlock", {15'b0, interlock}, {15'b0, ilock_m});
            chk("R5 random pwr_en", {15'b0, pwr_en}, {15'b0, ~d[10]});
            chk("R9 random irq", {15'b0, irq}, {15'b0, d[0]});
            if (d[9:8] != 2'b10) chk("R4 random pwr ind", {15'b0, pwr_ind}, {15'b0, ind_exp(d[9:8])});
            if (d[7:6] != 2'b10) chk("R4 random attn ind", {15'b0, attn_ind}, {15'b0, ind_exp(d[7:6])});
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule